// File: doc/BRIEF.md
# Masked Priority Interrupt Controller

This block collects a set of level-sensitive interrupt request lines and funnels them into a single interrupt towards a processor. Each asserted line is captured in a pending register. The block picks the highest-priority pending line that is neither masked nor held off by an interrupt already in service. It then raises `intr` and drives a vector number for that line.

After `intr` rises, the block is locked. The line and the vector stay frozen until the processor answers with `ack`. The acknowledge moves the line from pending to in-service. An `eoi` pulse from the processor retires the most urgent in-service line, and lower-priority requests wait until that happens. A small configuration port holds the mask and the vector base, and both can be read back.

Top module: `prio_irq_ctrl`

## Requirements
- R1: The mask register is at configuration address 0, with bit i covering line i. A 1 masks the line, and a masked line never causes `intr` to rise.
- R2: A line that is high at a clock edge sets its pending bit. The bit stays set until that line is acknowledged. A request that arrives while masked is delivered once the mask bit is cleared.
- R3: Among the eligible pending lines, the lowest-numbered line wins. `intr` rises on the second clock edge after a request is first sampled: one edge latches it and one edge raises the interrupt.
- R4: The vector base register is at configuration address 1. `vector` equals base plus line number, taken modulo 2^VW. `cfg_rdata` returns the register selected by `cfg_addr` without delay.
- R5: While `intr` is high and `ack` is low, `intr`, `vector` and the selected line hold their values. They hold even if requests or the mask change.
- R6: `ack` while `intr` is high drops `intr` at the next edge. At that edge the line's pending bit clears and its in-service bit sets. `ack` while `intr` is low has no effect.
- R7: A line is eligible only if its number is strictly lower than that of every in-service line. Lines of equal or lower priority wait.
- R8: An `eoi` pulse clears only the lowest-numbered in-service bit.
- R9: After reset, `intr` is low, `vector` is 0, both registers read 0, and nothing is pending or in service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | N | Level-sensitive request lines, bit 0 most urgent |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 1 | Register select: 0 mask, 1 vector base |
| cfg_wdata | input | VW | Configuration write data |
| cfg_rdata | output | VW | Read data of the selected register |
| intr | output | 1 | Interrupt to the processor |
| vector | output | VW | Vector number of the offered line |
| ack | input | 1 | Processor acknowledge |
| eoi | input | 1 | End-of-interrupt pulse |

## Verification
The assertions assume that `ack` and `eoi` arrive as clean single-cycle pulses from the processor side. They also assume that `eoi` is only sent when something is in service. The stimulus meets this by sending one `ack` per offered interrupt and one `eoi` after each acknowledge. The only deliberate exception is a stray `ack` while idle, which tests that it is ignored. Request lines are driven as one-cycle pulses between checks, so every expected vector follows from the latched pattern, the mask and the in-service set alone.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef enum logic {
    IRQC_REG_MASK = 1'b0,
    IRQC_REG_BASE = 1'b1
  } irqc_reg_e;
endpackage

// File: rtl/irqc_regs.sv
module irqc_regs
  import irqc_pkg::*;
#(
  parameter int N  = 8,
  parameter int VW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic          addr,
  input  logic [VW-1:0] wdata,
  output logic [VW-1:0] rdata,
  output logic [N-1:0]  mask,
  output logic [VW-1:0] base
);
  irqc_reg_e sel;
  assign sel = irqc_reg_e'(addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask <= '0;
      base <= '0;
    end else if (we) begin
      if (sel == IRQC_REG_MASK) mask <= wdata[N-1:0];
      else                      base <= wdata;
    end
  end

  always_comb begin
    rdata = base;
    if (sel == IRQC_REG_MASK) rdata = VW'(mask);
  end
endmodule

// File: rtl/irqc_track.sv
module irqc_track #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  irq,
  input  logic          ack_take,
  input  logic [IW-1:0] sel_line,
  input  logic          eoi,
  output logic [N-1:0]  irr,
  output logic [N-1:0]  isr
);
  function automatic logic [N-1:0] onehot(input logic [IW-1:0] idx);
    logic [N-1:0] v;
    for (int i = 0; i < N; i++) v[i] = (i == int'(idx));
    return v;
  endfunction

  function automatic logic [N-1:0] lowest_bit(input logic [N-1:0] v);
    return v & (~v + N'(1));
  endfunction

  logic [N-1:0] take_vec, retire_vec;
  assign take_vec   = ack_take ? onehot(sel_line) : '0;
  assign retire_vec = eoi ? lowest_bit(isr) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irr <= '0;
      isr <= '0;
    end else begin
      irr <= (irr | irq) & ~take_vec;
      isr <= (isr & ~retire_vec) | take_vec;
    end
  end

  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(irr) & ~$past(take_vec)) & ~irr) == '0);
  // R6
  isr_set_by_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((isr & ~$past(isr)) != '0) |-> $past(ack_take));
  // R8
  eoi_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && !ack_take && isr != '0) |=> $countones(isr) == $countones($past(isr)) - 1);
endmodule

// File: rtl/irqc_pick.sv
module irqc_pick #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  irr,
  input  logic [N-1:0]  mask,
  input  logic [N-1:0]  isr,
  output logic [N-1:0]  elig,
  output logic          any,
  output logic [IW-1:0] idx
);
  function automatic logic [N-1:0] above_service(input logic [N-1:0] s);
    logic [N-1:0] m;
    logic seen;
    seen = 1'b0;
    for (int i = 0; i < N; i++) begin
      seen = seen | s[i];
      m[i] = !seen;
    end
    return m;
  endfunction

  function automatic logic [IW-1:0] first_idx(input logic [N-1:0] v);
    logic [IW-1:0] r;
    r = '0;
    for (int i = N - 1; i >= 0; i--) if (v[i]) r = IW'(i);
    return r;
  endfunction

  assign elig = irr & ~mask & above_service(isr);
  assign any  = |elig;
  assign idx  = first_idx(elig);
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int N  = 8,
  parameter int VW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  irq_req,
  input  logic          cfg_we,
  input  logic          cfg_addr,
  input  logic [VW-1:0] cfg_wdata,
  output logic [VW-1:0] cfg_rdata,
  output logic          intr,
  output logic [VW-1:0] vector,
  input  logic          ack,
  input  logic          eoi
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  function automatic logic [VW-1:0] vec_of(input logic [VW-1:0] b, input logic [IW-1:0] i);
    return b + VW'(i);
  endfunction

  function automatic logic [N-1:0] lower_than(input logic [IW-1:0] i);
    logic [N-1:0] m;
    for (int k = 0; k < N; k++) m[k] = (k < int'(i));
    return m;
  endfunction

  logic [N-1:0]  mask_q, irr_q, isr_q, elig;
  logic [VW-1:0] base_q, vec_q;
  logic          intr_q, pick_any, ack_take, launch;
  logic [IW-1:0] pick_idx, sel_q;

  assign ack_take = intr_q & ack;
  assign launch   = !intr_q & pick_any;

  irqc_regs #(.N(N), .VW(VW)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .rdata(cfg_rdata), .mask(mask_q), .base(base_q)
  );

  irqc_track #(.N(N), .IW(IW)) u_track (
    .clk(clk), .rst_n(rst_n), .irq(irq_req), .ack_take(ack_take), .sel_line(sel_q),
    .eoi(eoi), .irr(irr_q), .isr(isr_q)
  );

  irqc_pick #(.N(N), .IW(IW)) u_pick (
    .irr(irr_q), .mask(mask_q), .isr(isr_q), .elig(elig), .any(pick_any), .idx(pick_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      intr_q <= 1'b0;
      sel_q  <= '0;
      vec_q  <= '0;
    end else if (intr_q) begin
      if (ack) intr_q <= 1'b0;
    end else if (launch) begin
      intr_q <= 1'b1;
      sel_q  <= pick_idx;
      vec_q  <= vec_of(base_q, pick_idx);
    end
  end

  assign intr   = intr_q;
  assign vector = vec_q;

  // R1
  mask_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(intr_q) |-> ($past(mask_q) & ~lower_than(sel_q) & lower_than(sel_q + IW'(1))) == '0
      || sel_q == IW'(N - 1) && !$past(mask_q[N-1]));
  // R3
  prio_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(intr_q) |-> ($past(elig) & lower_than(sel_q)) == '0);
  // R7
  holdoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(intr_q) |-> ($past(isr_q) & lower_than(sel_q + IW'(1))) == '0
      || (sel_q == IW'(N - 1) && $past(isr_q) == '0));
  // R4
  vec_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(intr_q) |-> vec_q == $past(base_q) + VW'(sel_q));
  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (intr_q && !ack) |=> intr_q && $stable(vec_q) && $stable(sel_q));
  // R6
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (intr_q && ack) |=> !intr_q);
endmodule

// File: tb/prio_irq_ctrl_bench.sv
module prio_irq_ctrl_bench;
  localparam int N  = 8;
  localparam int VW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  irq_req = '0;
  logic          cfg_we = 1'b0, cfg_addr = 1'b0, ack = 1'b0, eoi = 1'b0;
  logic [VW-1:0] cfg_wdata = '0;
  logic [VW-1:0] cfg_rdata, vector;
  logic          intr;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  prio_irq_ctrl #(.N(N), .VW(VW)) u_prio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .intr(intr), .vector(vector),
    .ack(ack), .eoi(eoi)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; irq_req = '0; ack = 0; eoi = 0; cfg_we = 0;
    tick();
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic a, input logic [VW-1:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic pulse(input logic [N-1:0] p);
    irq_req = p;
    tick();
    irq_req = '0;
  endtask

  // check offered line, acknowledge, retire, then let the next one launch
  task automatic serve(input int line, input logic [VW-1:0] base);
    chk("R3 intr", int'(intr), 1);
    chk("R4 vector", int'(vector), int'(VW'(base + VW'(line))));
    ack = 1'b1; tick(); ack = 1'b0;
    chk("R6 intr drops", int'(intr), 0);
    eoi = 1'b1; tick(); eoi = 1'b0;
    tick();
  endtask

  initial begin
    logic [VW-1:0] b;
    logic [N-1:0] m, live, held;
    do_reset();
    chk("R9 intr", int'(intr), 0);
    chk("R9 vector", int'(vector), 0);
    cfg_addr = 1'b0; #0; chk("R9 mask", int'(cfg_rdata), 0);
    cfg_addr = 1'b1; #1; chk("R9 base", int'(cfg_rdata), 0);

    // sweep every request pattern under two masks
    for (int mi = 0; mi < 2; mi++) begin
      for (int p = 1; p < (1 << N); p++) begin
        m = (mi == 0) ? N'(0) : N'(8'h5A);
        b = VW'(p * 37 + mi);
        do_reset();
        wr(1'b0, VW'(m));
        wr(1'b1, b);
        cfg_addr = 1'b0; #1; chk("R1 mask readback", int'(cfg_rdata), int'(m));
        cfg_addr = 1'b1; #1; chk("R4 base readback", int'(cfg_rdata), int'(b));
        pulse(N'(p));
        tick();
        live = N'(p) & ~m;
        held = N'(p) & m;
        for (int i = 0; i < N; i++) if (live[i]) serve(i, b);
        chk("R1 masked stays quiet", int'(intr), 0);
        wr(1'b0, '0);
        tick();
        for (int i = 0; i < N; i++) if (held[i]) serve(i, b);
        chk("R2 all drained", int'(intr), 0);
      end
    end

    // hold-off, stability and ignored acknowledge
    do_reset();
    wr(1'b1, 8'h40);
    pulse(8'h08); tick();
    chk("R3 line3", int'(vector), 8'h43);
    ack = 1; tick(); ack = 0;              // line 3 in service
    pulse(8'h20); tick();
    chk("R7 lower held", int'(intr), 0);
    pulse(8'h08); tick();
    chk("R7 equal held", int'(intr), 0);
    pulse(8'h02); tick();
    chk("R7 higher passes", int'(intr), 1);
    chk("R7 higher vector", int'(vector), 8'h41);
    wr(1'b0, 8'hFF);
    pulse(8'h01);
    chk("R5 intr held", int'(intr), 1);
    chk("R5 vector held", int'(vector), 8'h41);
    wr(1'b0, 8'h00);
    wr(1'b0, 8'hFE);                       // mask all but line 0, which stays pending
    ack = 1; tick(); ack = 0;              // in service: 1 and 3
    tick();
    chk("R1 masked pending line0 launches only if unmasked", int'(intr), 1);
    chk("R3 line0 vector", int'(vector), 8'h40);
    ack = 1; tick(); ack = 0;              // in service: 0,1,3
    wr(1'b0, 8'h00);
    tick();
    chk("R7 all blocked", int'(intr), 0);
    eoi = 1; tick(); eoi = 0; tick();      // retires 0
    chk("R8 still blocked after one eoi", int'(intr), 0);
    eoi = 1; tick(); eoi = 0; tick();      // retires 1
    chk("R8 line3 in service blocks 3,5", int'(intr), 0);
    eoi = 1; tick(); eoi = 0; tick();      // retires 3
    chk("R8 line3 released", int'(intr), 1);
    chk("R8 vector 3", int'(vector), 8'h43);
    ack = 1; tick(); ack = 0;
    eoi = 1; tick(); eoi = 0; tick();
    serve(5, 8'h40);
    chk("R6 idle", int'(intr), 0);
    ack = 1; tick(); ack = 0; tick();
    chk("R6 stray ack ignored", int'(intr), 0);
    pulse(8'h40); tick();
    chk("R6 no false in-service", int'(intr), 1);
    chk("R6 vector 6", int'(vector), 8'h46);

    // wrap of the vector sum
    do_reset();
    wr(1'b1, 8'hFC);
    pulse(8'h80); tick();
    chk("R4 wrap", int'(vector), 8'h03);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule